// File: doc/BRIEF.md
# Dual-Mode Pixel Serializer Front-End

This block takes parallel 18-bit colour pixels, together with two sync bits and four control bits, and sends them out as one serial bit stream. Each pixel becomes a 24-bit word. The stream runs on a fast bit clock, `clk_bit`, at 24 bits per pixel.

The shift clock that qualifies the parallel inputs is oversampled in the bit-clock domain. A strap input selects which edge of the shift clock captures the inputs. In one-pixel mode, each capture edge takes one pixel from the B input group. In two-pixel mode, each capture edge takes two pixels, and the A group is sent before the B group. This rebuilds a single pixel stream at the dot rate. Captured pixels pass through a small FIFO to a serializer. The serializer frames every 24-bit period and marks the first bit of each period.

Three controls can override the pixel data:
- An idle input forces the line low.
- An unsupported panel code forces the line low and raises an error flag.
- A reference-clock request replaces the data with a fixed clock pattern and is echoed on a status flag.

Top module: `pixser_tx`

## Requirements
- R1: While `rst_n` is low, the following hold at each rising clock edge: `sdata`, `word_valid`, `refreq_flag` and `panel_err` are 0, and `word_sync` is 1.
- R2: With `one_ppc` high, each capture edge of `shift_clk` queues exactly one pixel, taken from the B group. The values on the A group have no effect on the words sent.
- R3: A pixel word is {red[5:0], green[5:0], blue[5:0], hsync, vsync, ctl[3:0]}. It is sent MSB first: red[5] goes out in the bit period where `word_sync` is high, and ctl[0] goes out 23 periods later. `word_valid` is high for all 24 bits of a pixel word.
- R4: With `one_ppc` low, each capture edge queues two pixels. The A group is sent first and the B group next, and both carry the same hsync, vsync and ctl values.
- R5: With `edge_rise` high, inputs are captured on a rising edge of `shift_clk`. With `edge_rise` low, they are captured on a falling edge. Values present only at the other edge are not captured.
- R6: From the clock edge after `idle` is sampled high, `sdata` and `word_valid` stay low. Pixels queued while idle are discarded and are never sent later.
- R7: While `refclk_req` is in effect, each 24-bit period starting at `word_sync` carries 12 ones followed by 12 zeros, and `word_valid` is low.
- R8: `refreq_flag` equals the value `refclk_req` had at the previous clock edge.
- R9: `panel_err` equals 1 exactly when `panel_sel` was 2'b11 at the previous clock edge. While it is set, `sdata` and `word_valid` stay low.
- R10: When `idle` and `refclk_req` are both high, `idle` wins and `sdata` stays low.
- R11: `word_sync` pulses for one cycle every 24 cycles. When the FIFO is empty at a word boundary, the whole period is sent as zeros with `word_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_clk | input | 1 | Shift clock qualifying the parallel inputs |
| a_red | input | 6 | First-pixel red (two-pixel mode only) |
| a_grn | input | 6 | First-pixel green (two-pixel mode only) |
| a_blu | input | 6 | First-pixel blue (two-pixel mode only) |
| b_red | input | 6 | Second-pixel red, or the only pixel in one-pixel mode |
| b_grn | input | 6 | Second-pixel green |
| b_blu | input | 6 | Second-pixel blue |
| hsync | input | 1 | Horizontal sync bit |
| vsync | input | 1 | Vertical sync bit |
| ctl | input | 4 | Control bits |
| one_ppc | input | 1 | 1: one pixel per shift clock; 0: two pixels |
| panel_sel | input | 2 | Panel code; 2'b11 is unsupported |
| edge_rise | input | 1 | 1: capture on rising edge; 0: capture on falling edge |
| idle | input | 1 | Forces the serial line low |
| refclk_req | input | 1 | Requests the reference clock pattern |
| sdata | output | 1 | Serial data |
| word_sync | output | 1 | High during the first bit period of each word |
| word_valid | output | 1 | High while a pixel word is on `sdata` |
| refreq_flag | output | 1 | Registered echo of `refclk_req` |
| panel_err | output | 1 | Unsupported panel code seen |

## Verification
The control results are due one cycle after their stimulus, because `refreq_flag`, `panel_err` and the idle gate each pass through a single register. The bench changes inputs on a falling edge and samples on the next falling edge.

The delay from a capture edge to the serial word depends on the phase of the free-running 24-cycle frame. It is at most about 50 cycles. So the bench does not expect a pixel at a fixed cycle. Instead, it collects every 24-bit period that begins with `word_sync` and `word_valid` high, and compares the queue of received words with the expected order.

Pattern and gating checks watch `sdata` over whole frames, starting at `word_sync`.

// File: rtl/pixser_tx.sv
module pixser_tx #(
  parameter int CW    = 6,
  parameter int CTLW  = 4,
  parameter int DEPTH = 4
) (
  input  logic            clk_bit,
  input  logic            rst_n,
  input  logic            shift_clk,
  input  logic [CW-1:0]   a_red,
  input  logic [CW-1:0]   a_grn,
  input  logic [CW-1:0]   a_blu,
  input  logic [CW-1:0]   b_red,
  input  logic [CW-1:0]   b_grn,
  input  logic [CW-1:0]   b_blu,
  input  logic            hsync,
  input  logic            vsync,
  input  logic [CTLW-1:0] ctl,
  input  logic            one_ppc,
  input  logic [1:0]      panel_sel,
  input  logic            edge_rise,
  input  logic            idle,
  input  logic            refclk_req,
  output logic            sdata,
  output logic            word_sync,
  output logic            word_valid,
  output logic            refreq_flag,
  output logic            panel_err
);
  localparam int WW   = 3*CW + 2 + CTLW;
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(WW);
  localparam logic [AW:0]     FULLV = DEPTH[AW:0];
  localparam logic [CNTW-1:0] LASTB = CNTW'(WW-1);
  localparam logic [CNTW-1:0] HALFB = CNTW'(WW/2);

  wire [WW-1:0] a_w = {a_red, a_grn, a_blu, hsync, vsync, ctl};
  wire [WW-1:0] b_w = {b_red, b_grn, b_blu, hsync, vsync, ctl};

  logic          sck_q, sck_qq;
  logic [WW-1:0] a_q, b_q, pend;
  logic          pend_v;
  logic          idle_q, req_q, perr_q;

  always_ff @(posedge clk_bit) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      sck_qq <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      idle_q <= 1'b0;
      req_q  <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      sck_q  <= shift_clk;
      sck_qq <= sck_q;
      a_q    <= a_w;
      b_q    <= b_w;
      idle_q <= idle;
      req_q  <= refclk_req;
      perr_q <= (panel_sel == 2'b11);
    end
  end

  wire cap = edge_rise ? (sck_q & ~sck_qq) : (~sck_q & sck_qq);

  always_ff @(posedge clk_bit) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend   <= '0;
    end else begin
      pend_v <= cap & ~one_ppc;
      if (cap & ~one_ppc) pend <= b_q;
    end
  end

  wire          push = cap | pend_v;
  wire [WW-1:0] wdat = pend_v ? pend : (one_ppc ? b_q : a_q);

  logic [WW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [AW:0]     fcnt;
  logic [CNTW-1:0] bit_cnt;
  logic [WW-1:0]   sh;
  logic            ld_v;

  wire last = (bit_cnt == LASTB);
  wire pop  = last & (fcnt != '0);
  wire wr   = push & ((fcnt != FULLV) | pop);

  always_ff @(posedge clk_bit) begin
    if (wr) mem[wp] <= wdat;
  end

  always_ff @(posedge clk_bit) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fcnt <= '0;
    end else begin
      if (wr)  wp <= wp + 1'b1;
      if (pop) rp <= rp + 1'b1;
      case ({wr, pop})
        2'b10:   fcnt <= fcnt + 1'b1;
        2'b01:   fcnt <= fcnt - 1'b1;
        default: fcnt <= fcnt;
      endcase
    end
  end

  always_ff @(posedge clk_bit) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      sh      <= '0;
      ld_v    <= 1'b0;
    end else if (last) begin
      bit_cnt <= '0;
      sh      <= pop ? mem[rp] : '0;
      ld_v    <= pop;
    end else begin
      bit_cnt <= bit_cnt + 1'b1;
      sh      <= sh << 1;
    end
  end

  wire gate = idle_q | perr_q;

  assign sdata       = gate ? 1'b0 : (req_q ? (bit_cnt < HALFB) : sh[WW-1]);
  assign word_sync   = (bit_cnt == '0);
  assign word_valid  = ld_v & ~gate & ~req_q;
  assign refreq_flag = req_q;
  assign panel_err   = perr_q;
endmodule

// File: rtl/pixser_tx_chk.sv
module pixser_tx_chk (
  input logic       clk_bit,
  input logic       rst_n,
  input logic       idle,
  input logic       refclk_req,
  input logic [1:0] panel_sel,
  input logic       sdata,
  input logic       word_sync,
  input logic       word_valid,
  input logic       refreq_flag,
  input logic       panel_err
);
  AST_IDLE_QUIET: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $past(rst_n) && $past(idle) |-> !sdata && !word_valid); // R6

  AST_IDLE_OVER_REF: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $past(rst_n) && $past(idle) && $past(refclk_req) |-> !sdata); // R10

  AST_FLAG_TRACK: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $past(rst_n) |-> refreq_flag == $past(refclk_req)); // R8

  AST_PANEL_FLAG: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $past(rst_n) |-> panel_err == ($past(panel_sel) == 2'b11)); // R9

  AST_PANEL_QUIET: assert property (@(posedge clk_bit) disable iff (!rst_n)
    panel_err |-> !sdata && !word_valid); // R9

  AST_REF_HEAD: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $past(rst_n) && refreq_flag && !panel_err && !$past(idle) && word_sync |-> sdata); // R7

  AST_REF_NOT_PIXEL: assert property (@(posedge clk_bit) disable iff (!rst_n)
    word_valid |-> !refreq_flag); // R7

  AST_SYNC_GAP: assert property (@(posedge clk_bit) disable iff (!rst_n)
    word_sync |=> !word_sync); // R11
endmodule

bind pixser_tx pixser_tx_chk u_chk (
  .clk_bit(clk_bit), .rst_n(rst_n), .idle(idle), .refclk_req(refclk_req),
  .panel_sel(panel_sel), .sdata(sdata), .word_sync(word_sync),
  .word_valid(word_valid), .refreq_flag(refreq_flag), .panel_err(panel_err)
);

// File: tb/test_pixser_tx.sv
module test_pixser_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_clk = 1'b0;
  logic [5:0] a_red = '0, a_grn = '0, a_blu = '0, b_red = '0, b_grn = '0, b_blu = '0;
  logic hsync = 1'b0, vsync = 1'b0;
  logic [3:0] ctl = '0;
  logic one_ppc = 1'b1;
  logic [1:0] panel_sel = 2'b10;
  logic edge_rise = 1'b1;
  logic idle = 1'b0;
  logic refclk_req = 1'b0;
  logic sdata, word_sync, word_valid, refreq_flag, panel_err;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [23:0] got[$];
  logic [23:0] exp[$];
  logic [23:0] acc;
  int nb = 0;

  always #5 clk = ~clk;

  pixser_tx i_pixser_tx (
    .clk_bit(clk), .rst_n(rst_n), .shift_clk(shift_clk),
    .a_red(a_red), .a_grn(a_grn), .a_blu(a_blu),
    .b_red(b_red), .b_grn(b_grn), .b_blu(b_blu),
    .hsync(hsync), .vsync(vsync), .ctl(ctl),
    .one_ppc(one_ppc), .panel_sel(panel_sel), .edge_rise(edge_rise),
    .idle(idle), .refclk_req(refclk_req),
    .sdata(sdata), .word_sync(word_sync), .word_valid(word_valid),
    .refreq_flag(refreq_flag), .panel_err(panel_err)
  );

  always @(negedge clk) begin
    if (word_sync && word_valid) begin
      acc = {23'd0, sdata};
      nb = 1;
    end else if (nb > 0) begin
      acc = {acc[22:0], sdata};
      nb = nb + 1;
      if (nb == 24) begin
        got.push_back(acc);
        nb = 0;
      end
    end
  end

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      report();
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_in(input logic [23:0] aw, input logic [23:0] bw);
    {a_red, a_grn, a_blu} = aw[23:6];
    {b_red, b_grn, b_blu} = bw[23:6];
    {hsync, vsync, ctl} = bw[5:0];
  endtask

  task automatic drive_pix(input logic [23:0] aw, input logic [23:0] bw,
                           input logic [23:0] junk, input int w);
    set_in(aw, bw);
    step(w);
    shift_clk = edge_rise;
    step(w);
    set_in(junk, junk);
    step(w);
    shift_clk = ~edge_rise;
    step(w);
  endtask

  task automatic compare_words(input string tag);
    step(120);
    check(got.size() == exp.size(), {tag, " word count"}, got.size(), exp.size());
    if (got.size() == exp.size())
      foreach (exp[i]) check(got[i] === exp[i], tag, got[i], exp[i]);
    got.delete();
    exp.delete();
  endtask

  task automatic t_reset;
    step(3);
    check(sdata === 1'b0 && word_valid === 1'b0, "R1 data/valid in reset", {sdata, word_valid}, 0);
    check(refreq_flag === 1'b0 && panel_err === 1'b0, "R1 flags in reset", {refreq_flag, panel_err}, 0);
    check(word_sync === 1'b1, "R1 sync in reset", word_sync, 1);
    rst_n = 1'b1;
    step(2);
  endtask

  task automatic t_frame;
    int gap;
    bit any;
    while (!word_sync) step(1);
    gap = 0;
    step(1);
    gap = 1;
    while (!word_sync && gap < 100) begin step(1); gap++; end
    check(gap == 24, "R11 sync period", gap, 24);
    any = 1'b0;
    repeat (48) begin step(1); if (sdata || word_valid) any = 1'b1; end
    check(!any, "R11 empty fifo sends zeros", any, 0);
  endtask

  task automatic t_one_ppc;
    one_ppc = 1'b1;
    got.delete(); exp.delete();
    drive_pix(24'hAAAAAA, 24'h84_1_0_25, 24'h555555, 6);
    exp.push_back(24'h84_1_0_25);
    drive_pix(24'h3C3C3C, 24'h0FF00F, 24'h123456, 6);
    exp.push_back(24'h0FF00F);
    drive_pix(24'hFFFFFF, 24'h000001, 24'hC0FFEE, 6);
    exp.push_back(24'h000001);
    compare_words("R2 one pixel per clock from B group");
    drive_pix(24'h0, 24'h800000, 24'h0, 6);
    exp.push_back(24'h800000);
    compare_words("R3 red msb first bit");
    drive_pix(24'h0, 24'h000020, 24'h0, 6);
    exp.push_back(24'h000020);
    compare_words("R3 hsync position");
  endtask

  task automatic t_two_ppc;
    one_ppc = 1'b0;
    drive_pix(24'h111129, 24'h2222A9, 24'h000000, 12);
    exp.push_back(24'h111129);
    exp.push_back(24'h2222A9);
    drive_pix(24'hABCDE6, 24'h987666, 24'hFFFFFF, 12);
    exp.push_back(24'hABCDE6);
    exp.push_back(24'h987666);
    compare_words("R4 two pixels A then B");
    one_ppc = 1'b1;
  endtask

  task automatic t_edge_fall;
    edge_rise = 1'b0;
    shift_clk = 1'b1;
    step(6);
    drive_pix(24'h0, 24'h5A5A5A, 24'hA5A5A5, 6);
    exp.push_back(24'h5A5A5A);
    drive_pix(24'h0, 24'h00F0F1, 24'hF00F00, 6);
    exp.push_back(24'h00F0F1);
    compare_words("R5 falling edge capture");
    edge_rise = 1'b1;
    shift_clk = 1'b0;
    step(6);
    drive_pix(24'h0, 24'h314159, 24'h271828, 6);
    exp.push_back(24'h314159);
    compare_words("R5 rising edge capture");
  endtask

  task automatic t_idle;
    bit any;
    idle = 1'b1;
    step(1);
    check(sdata === 1'b0 && word_valid === 1'b0, "R6 idle one cycle later", {sdata, word_valid}, 0);
    any = 1'b0;
    fork
      begin
        drive_pix(24'h0, 24'hFFFFFF, 24'hFFFFFF, 6);
        drive_pix(24'h0, 24'hFEDCBA, 24'hFFFFFF, 6);
        step(60);
      end
      begin
        repeat (100) begin step(1); if (sdata || word_valid) any = 1'b1; end
      end
    join
    check(!any, "R6 idle line low", any, 0);
    idle = 1'b0;
    step(30);
    drive_pix(24'h0, 24'h13579B, 24'h0, 6);
    exp.push_back(24'h13579B);
    compare_words("R6 idle pixels discarded");
  endtask

  task automatic t_ref;
    logic [23:0] pat;
    bit vis;
    refclk_req = 1'b1;
    step(1);
    check(refreq_flag === 1'b1, "R8 flag rises", refreq_flag, 1);
    step(1);
    while (!word_sync) step(1);
    pat = '0;
    vis = 1'b0;
    for (int k = 0; k < 24; k++) begin
      pat = {pat[22:0], sdata};
      if (word_valid) vis = 1'b1;
      step(1);
    end
    check(pat === 24'hFFF000, "R7 reference pattern", pat, 24'hFFF000);
    check(!vis, "R7 no pixel valid during pattern", vis, 0);
    refclk_req = 1'b0;
    step(1);
    check(refreq_flag === 1'b0, "R8 flag falls", refreq_flag, 0);
  endtask

  task automatic t_both;
    bit any;
    idle = 1'b1;
    refclk_req = 1'b1;
    step(2);
    any = 1'b0;
    repeat (50) begin if (sdata) any = 1'b1; step(1); end
    check(!any, "R10 idle beats reference request", any, 0);
    idle = 1'b0;
    refclk_req = 1'b0;
    step(30);
  endtask

  task automatic t_panel;
    bit any;
    panel_sel = 2'b11;
    step(1);
    check(panel_err === 1'b1, "R9 error flag set", panel_err, 1);
    any = 1'b0;
    fork
      begin
        drive_pix(24'h0, 24'hFFFFFF, 24'h0, 6);
        step(60);
      end
      begin
        repeat (80) begin step(1); if (sdata || word_valid) any = 1'b1; end
      end
    join
    check(!any, "R9 line low on bad panel", any, 0);
    panel_sel = 2'b01;
    step(1);
    check(panel_err === 1'b0, "R9 error flag clears", panel_err, 0);
    step(30);
    check(got.size() == 0, "R9 no words during error", got.size(), 0);
    got.delete();
  endtask

  initial begin
    t_reset();
    t_frame();
    t_one_ppc();
    t_two_ppc();
    t_edge_fall();
    t_idle();
    t_ref();
    t_both();
    t_panel();
    done = 1'b1;
    report();
  end
endmodule